// File: doc/BRIEF.md
# Palette Colour Overlay for a YCbCr Pixel Stream

This block draws on-screen graphics onto a 4:4:4-style component stream (one Y, Cb and Cr byte per clock) by replacing chosen pixels with solid colours from a small palette. The palette has eight 12-bit colours, each made of a 4-bit Y, a 4-bit Cb and a 4-bit Cr value. The colours are packed into twelve 8-bit storage registers. The palette is filled through the video inputs themselves: while the load control is high, the upper nibbles of the three component bytes are captured once per clock, one colour per cycle.

For each pixel, a 3-bit colour select and an overlay enable decide whether the output shows the selected palette colour or the original video. No rectangle or position registers exist. The enable alone shapes the overlay, so it can cover one pixel, the whole frame, or a region whose width changes from line to line. Select, enable and video all pass through the same single register stage, so an overlay decision always applies to the pixel presented on the same clock edge.

Top module: `osd_overlay`

## Requirements
- R1: While rst_n is low at a rising edge, all three outputs become 0x00, the pointer to the next palette entry to be written returns to entry 0, and all twelve palette registers clear, so every palette colour reads as Y=Cb=Cr=0.
- R2: When ovl_en is low at a rising edge, each output after that edge equals the matching input byte sampled at that edge, whatever the state of col_sel and pal_load.
- R3: When ovl_en is high at a rising edge, the outputs after that edge carry the palette entry chosen by col_sel at that same edge. The 4-bit Y, Cb and Cr values occupy bits [7:4] of y_out, cb_out and cr_out.
- R4: With the default FILL_MODE (zero fill), bits [3:0] of each substituted output byte are 0000. In repeat mode they copy bits [7:4].
- R5: On each rising edge with pal_load high, the palette entry at the write pointer takes {y_in[7:4], cb_in[7:4], cr_in[7:4]} as its Y, Cb and Cr values, and the pointer advances by one. Entry 7 is followed by entry 0. Any edge with pal_load low puts the pointer back to entry 0, so every load burst starts at entry 0 and fills entries in ascending order.
- R6: Palette contents do not change on edges where pal_load is low. The lower input nibbles are never stored.
- R7: The overlay follows ovl_en pixel by pixel. Toggling ovl_en on every clock alternates substituted and original pixels with no extra delay or smearing.
- R8: When pal_load and ovl_en are both high on the same edge, the substituted colour is the palette content from before that edge's write. A burst longer than eight cycles overwrites again from entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| y_in | input | 8 | Luma byte of the incoming pixel |
| cb_in | input | 8 | Blue-difference byte of the incoming pixel |
| cr_in | input | 8 | Red-difference byte of the incoming pixel |
| pal_load | input | 1 | High: capture upper nibbles into the next palette entry |
| col_sel | input | 3 | Palette entry to show for this pixel |
| ovl_en | input | 1 | High: replace this pixel with the palette colour |
| y_out | output | 8 | Luma byte after overlay |
| cb_out | output | 8 | Blue-difference byte after overlay |
| cr_out | output | 8 | Red-difference byte after overlay |

## Verification
Every result of this block appears exactly one rising edge after the inputs that cause it, because video, select and enable share one register stage. A palette write becomes visible to an overlay on the edge after the write. The bench drives new inputs on each falling edge and, at that same falling edge, compares the outputs against a behavioural prediction. That prediction was made when the previous inputs were applied, so each comparison lands on the cycle in which the result is due. The model makes its prediction from the palette state before it applies the same cycle's load. This reproduces the read-before-write ordering of R8 without mirroring the register packing.

// File: rtl/osd_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the palette overlay.
// Assumes three colour components per pixel, in the order Y, Cb, Cr.
package osd_pkg;
    localparam int NUM_COMP = 3;

    typedef enum logic {
        FILL_ZERO   = 1'b0,
        FILL_REPEAT = 1'b1
    } fill_e;

    typedef enum logic [1:0] {
        COMP_Y  = 2'd0,
        COMP_CB = 2'd1,
        COMP_CR = 2'd2
    } comp_e;
endpackage

// File: rtl/osd_palette.sv
`timescale 1ns/1ps
// Palette store: ENTRIES colours of NUM_COMP nibbles each, packed into
// REG_W-bit registers. Nibble k = entry*NUM_COMP + component lives in
// register k/NIBS_PER_REG, in the low half when k is even.
// Writes one whole entry per load cycle at an auto-incrementing pointer.
// Reads are combinational and show the contents before the current edge.
// Assumes ENTRIES is a power of two and REG_W is a multiple of NIB_W.
module osd_palette
    import osd_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int REG_W   = 8,
    parameter int ENTRIES = 8,
    localparam int PTR_W        = $clog2(ENTRIES),
    localparam int NIBS         = ENTRIES * NUM_COMP,
    localparam int NIBS_PER_REG = REG_W / NIB_W,
    localparam int NUM_REGS     = NIBS / NIBS_PER_REG,
    localparam int FLAT_W       = NUM_REGS * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NIB_W-1:0] wr_y,
    input  logic [NIB_W-1:0] wr_cb,
    input  logic [NIB_W-1:0] wr_cr,
    input  logic [PTR_W-1:0] rd_sel,
    output logic [NIB_W-1:0] rd_y,
    output logic [NIB_W-1:0] rd_cb,
    output logic [NIB_W-1:0] rd_cr
);
    logic [REG_W-1:0]  pal_q [NUM_REGS];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [FLAT_W-1:0] pal_flat;

    // Purpose: lay the register bank out as one flat nibble vector for reads.
    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_flat
            assign pal_flat[r*REG_W +: REG_W] = pal_q[r];
        end
    endgenerate

    // Purpose: select the write nibble for a given component index.
    function automatic logic [NIB_W-1:0] comp_nib(input int comp);
        case (comp)
            int'(COMP_Y):  comp_nib = wr_y;
            int'(COMP_CB): comp_nib = wr_cb;
            default:       comp_nib = wr_cr;
        endcase
    endfunction

    // Purpose: write pointer restarts when load is low and steps on each load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !load) begin
            wr_ptr_q <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_q + 1'b1;
        end
    end

    // Purpose: store the three nibbles of the addressed entry into their packed slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                pal_q[r] <= '0;
            end
        end else if (load) begin
            for (int k = 0; k < NIBS; k++) begin
                if (int'(wr_ptr_q) == k / NUM_COMP) begin
                    pal_q[k / NIBS_PER_REG][(k % NIBS_PER_REG)*NIB_W +: NIB_W] <= comp_nib(k % NUM_COMP);
                end
            end
        end
    end

    // Purpose: fetch the selected entry's nibbles from the flat view.
    always_comb begin
        int base;
        base  = int'(rd_sel) * NUM_COMP * NIB_W;
        rd_y  = pal_flat[base + int'(COMP_Y)*NIB_W  +: NIB_W];
        rd_cb = pal_flat[base + int'(COMP_CB)*NIB_W +: NIB_W];
        rd_cr = pal_flat[base + int'(COMP_CR)*NIB_W +: NIB_W];
    end

    // R5: a cycle without load sends the next write back to entry 0
    assert_ptr_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (wr_ptr_q == '0));
    // R5: each load cycle steps the pointer by one, wrapping after the last entry
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (wr_ptr_q == PTR_W'($past(wr_ptr_q) + 1'b1)));
    // R6: palette contents hold while load is low
    assert_pal_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pal_flat));
    // R1: reset clears the whole palette
    assert_pal_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (pal_flat == '0));
endmodule

// File: rtl/osd_subst.sv
`timescale 1ns/1ps
// Substitution stage: one register per component that holds either the
// input byte or the palette nibble widened to a full byte.
// FILL_MODE picks how the lower bits are filled. Assumes COMP_W is a
// multiple of NIB_W.
module osd_subst
    import osd_pkg::*;
#(
    parameter int    COMP_W    = 8,
    parameter int    NIB_W     = 4,
    parameter fill_e FILL_MODE = FILL_ZERO,
    localparam int   REPS      = COMP_W / NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [COMP_W-1:0] vid_y,
    input  logic [COMP_W-1:0] vid_cb,
    input  logic [COMP_W-1:0] vid_cr,
    input  logic [NIB_W-1:0]  pal_y,
    input  logic [NIB_W-1:0]  pal_cb,
    input  logic [NIB_W-1:0]  pal_cr,
    output logic [COMP_W-1:0] out_y,
    output logic [COMP_W-1:0] out_cb,
    output logic [COMP_W-1:0] out_cr
);
    logic [COMP_W-1:0] wide_y, wide_cb, wide_cr;

    // Purpose: widen palette nibbles to output bytes using the chosen fill variant.
    generate
        if (FILL_MODE == FILL_REPEAT) begin : g_repeat
            assign wide_y  = {REPS{pal_y}};
            assign wide_cb = {REPS{pal_cb}};
            assign wide_cr = {REPS{pal_cr}};
        end else begin : g_zero
            assign wide_y  = {pal_y,  {(COMP_W-NIB_W){1'b0}}};
            assign wide_cb = {pal_cb, {(COMP_W-NIB_W){1'b0}}};
            assign wide_cr = {pal_cr, {(COMP_W-NIB_W){1'b0}}};
        end
    endgenerate

    // Purpose: register either video or palette colour, aligned with the sampled pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_y  <= '0;
            out_cb <= '0;
            out_cr <= '0;
        end else if (en) begin
            out_y  <= wide_y;
            out_cb <= wide_cb;
            out_cr <= wide_cr;
        end else begin
            out_y  <= vid_y;
            out_cb <= vid_cb;
            out_cr <= vid_cr;
        end
    end

    // R2: without enable the pixel passes with one cycle of delay
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_y == $past(vid_y) && out_cb == $past(vid_cb) && out_cr == $past(vid_cr)));
    // R3: with enable the upper nibbles carry the palette colour
    assert_subst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (out_y[COMP_W-1 -: NIB_W] == $past(pal_y) &&
                out_cb[COMP_W-1 -: NIB_W] == $past(pal_cb) &&
                out_cr[COMP_W-1 -: NIB_W] == $past(pal_cr)));
    // R4: lower bits follow the fill rule on substituted pixels
    assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((FILL_MODE == FILL_REPEAT) ?
                (out_y[NIB_W-1:0] == out_y[COMP_W-1 -: NIB_W]) :
                (out_y[NIB_W-1:0] == '0 && out_cb[NIB_W-1:0] == '0 && out_cr[NIB_W-1:0] == '0)));
    // R1: reset drives the outputs to zero
    assert_out_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (out_y == '0 && out_cb == '0 && out_cr == '0));
endmodule

// File: rtl/osd_overlay.sv
`timescale 1ns/1ps
// Top of the palette overlay: palette store plus substitution stage.
// Select, enable and video share one register stage, so an overlay
// decision applies to the pixel sampled on the same edge.
module osd_overlay
    import osd_pkg::*;
#(
    parameter int    COMP_W    = 8,
    parameter int    NIB_W     = 4,
    parameter int    REG_W     = 8,
    parameter int    ENTRIES   = 8,
    parameter fill_e FILL_MODE = FILL_ZERO,
    localparam int   SEL_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COMP_W-1:0] y_in,
    input  logic [COMP_W-1:0] cb_in,
    input  logic [COMP_W-1:0] cr_in,
    input  logic              pal_load,
    input  logic [SEL_W-1:0]  col_sel,
    input  logic              ovl_en,
    output logic [COMP_W-1:0] y_out,
    output logic [COMP_W-1:0] cb_out,
    output logic [COMP_W-1:0] cr_out
);
    logic [NIB_W-1:0] sel_y, sel_cb, sel_cr;

    osd_palette #(
        .NIB_W   (NIB_W),
        .REG_W   (REG_W),
        .ENTRIES (ENTRIES)
    ) u_palette (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (pal_load),
        .wr_y   (y_in[COMP_W-1 -: NIB_W]),
        .wr_cb  (cb_in[COMP_W-1 -: NIB_W]),
        .wr_cr  (cr_in[COMP_W-1 -: NIB_W]),
        .rd_sel (col_sel),
        .rd_y   (sel_y),
        .rd_cb  (sel_cb),
        .rd_cr  (sel_cr)
    );

    osd_subst #(
        .COMP_W    (COMP_W),
        .NIB_W     (NIB_W),
        .FILL_MODE (FILL_MODE)
    ) u_subst (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ovl_en),
        .vid_y  (y_in),
        .vid_cb (cb_in),
        .vid_cr (cr_in),
        .pal_y  (sel_y),
        .pal_cb (sel_cb),
        .pal_cr (sel_cr),
        .out_y  (y_out),
        .out_cb (cb_out),
        .out_cr (cr_out)
    );
endmodule

// File: tb/osd_overlay_test.sv
`timescale 1ns/1ps
// Bench for osd_overlay: a behavioural model predicts each output one edge ahead.
module osd_overlay_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] y_in = '0, cb_in = '0, cr_in = '0;
    logic       pal_load = 1'b0;
    logic [2:0] col_sel = '0;
    logic       ovl_en = 1'b0;
    logic [7:0] y_out, cb_out, cr_out;

    int tests = 0;
    int failed = 0;
    bit done = 0;

    // model state
    int m_y[8], m_cb[8], m_cr[8];
    int m_ptr = 0;
    int exp_y = 0, exp_cb = 0, exp_cr = 0;
    bit exp_valid = 0;
    string exp_tag = "R1";

    osd_overlay uut (
        .clk(clk), .rst_n(rst_n), .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
        .pal_load(pal_load), .col_sel(col_sel), .ovl_en(ovl_en),
        .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out)
    );

    always #2.5 clk = ~clk;

    task automatic compare();
        if (exp_valid) begin
            tests++;
            if (int'(y_out) != exp_y || int'(cb_out) != exp_cb || int'(cr_out) != exp_cr) begin
                failed++;
                $display("FAIL %s: got %02h/%02h/%02h expected %02h/%02h/%02h",
                         exp_tag, y_out, cb_out, cr_out, exp_y, exp_cb, exp_cr);
            end
        end
    endtask

    // one clock: check previous prediction, apply inputs, predict next output
    task automatic cycle(input bit r, input bit ld, input bit e, input int s,
                         input int yy, input int cc, input int rr, input string tag);
        @(negedge clk);
        compare();
        rst_n = r; pal_load = ld; ovl_en = e; col_sel = 3'(s);
        y_in = 8'(yy); cb_in = 8'(cc); cr_in = 8'(rr);
        exp_valid = 1; exp_tag = tag;
        if (!r) begin
            exp_y = 0; exp_cb = 0; exp_cr = 0; m_ptr = 0;
            for (int i = 0; i < 8; i++) begin m_y[i] = 0; m_cb[i] = 0; m_cr[i] = 0; end
        end else begin
            if (e) begin
                exp_y = m_y[s] * 16; exp_cb = m_cb[s] * 16; exp_cr = m_cr[s] * 16;
            end else begin
                exp_y = yy & 255; exp_cb = cc & 255; exp_cr = rr & 255;
            end
            if (ld) begin
                m_y[m_ptr] = (yy >> 4) & 15; m_cb[m_ptr] = (cc >> 4) & 15; m_cr[m_ptr] = (rr >> 4) & 15;
                m_ptr = (m_ptr + 1) % 8;
            end else begin
                m_ptr = 0;
            end
        end
    endtask

    initial begin
        // R1: reset state, including overlay reading a cleared palette
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 8'hA5, 8'h5A, 8'h3C, "R1 reset");
        for (int i = 0; i < 8; i++) cycle(1, 0, 1, i, 8'hFF, 8'hFF, 8'hFF, "R1 cleared palette");
        // R2: pass-through with varying select and load low
        for (int i = 0; i < 20; i++)
            cycle(1, 0, 0, $urandom % 8, $urandom % 256, $urandom % 256, $urandom % 256, "R2 passthrough");
        // R5: load eight distinct entries, low nibbles noisy (R6)
        for (int i = 0; i < 8; i++)
            cycle(1, 1, 0, 0, i*16 + 16 + (i ^ 5), (15 - i)*16 + 9, ((i*3) % 16)*16 + 6, "R5 load");
        // R3/R4: show each loaded entry
        for (int i = 0; i < 8; i++) cycle(1, 0, 1, 7 - i, 8'h12, 8'h34, 8'h56, "R3 R4 overlay");
        // R6: idle video, then confirm palette unchanged
        for (int i = 0; i < 10; i++)
            cycle(1, 0, 0, i % 8, $urandom % 256, $urandom % 256, $urandom % 256, "R6 idle");
        for (int i = 0; i < 8; i++) cycle(1, 0, 1, i, 8'h00, 8'h00, 8'h00, "R6 palette held");
        // R7: single-pixel and alternating windows
        for (int i = 0; i < 16; i++)
            cycle(1, 0, i % 2 == 1, (i * 3) % 8, i * 17, 255 - i, i * 5, "R7 toggle");
        cycle(1, 0, 1, 2, 8'h77, 8'h88, 8'h99, "R7 single pixel");
        cycle(1, 0, 0, 2, 8'h77, 8'h88, 8'h99, "R7 after single pixel");
        // R8: 11-cycle burst with overlay active on the same edges (wraps to entry 0)
        for (int i = 0; i < 11; i++)
            cycle(1, 1, 1, i % 8, (i*7 % 16)*16, (i*11 % 16)*16 + 3, (i*13 % 16)*16 + 12, "R8 load+overlay");
        for (int i = 0; i < 8; i++) cycle(1, 0, 1, i, 0, 0, 0, "R8 after wrap");
        // R5: short burst restarts at entry 0
        for (int i = 0; i < 2; i++) cycle(1, 1, 0, 0, 8'hE0, 8'hD0 + i*16 - 32*i, 8'h10, "R5 short burst");
        for (int i = 0; i < 8; i++) cycle(1, 0, 1, i, 0, 0, 0, "R5 restart check");
        // R1: reset mid-run
        cycle(0, 1, 1, 3, 8'hFF, 8'hFF, 8'hFF, "R1 mid reset");
        for (int i = 0; i < 8; i++) cycle(1, 0, 1, i, 8'hAB, 8'hCD, 8'hEF, "R1 palette after reset");
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            tests++;
            failed++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end
endmodule